// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit offset into a 20-bit physical memory address. It does so in the way a real-mode processor does. Six 16-bit segment registers are held inside the block, and software loads them through a simple write port. Each register names the base of a 64 KB window. A window always starts on a 16-byte boundary, so the physical address is the register value shifted left by four bits plus the offset, taken modulo 2^20. Windows may touch, sit apart or overlap, and no check is made between them.

Each request carries an access kind. The block picks the segment from that kind:

- Instruction fetches use the code segment.
- Stack accesses use the stack segment.
- General data and string-source accesses use the primary data segment.
- String-destination accesses use the extra segment.

An override input can redirect general data and string-source accesses to any of the six segments. Port accesses skip segmentation altogether: the 16-bit port number goes out zero-extended, and a flag marks the result as belonging to the separate 64 KB I/O space.

A request is taken in one cycle and its result appears, registered, in the next cycle. A segment write accepted in a cycle is first seen by requests issued in the following cycle.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, all six segment registers read 0, and addr_valid, addr_out and addr_is_io are all 0.
- R2: A legal request accepted in cycle N sets addr_valid in cycle N+1. For a memory request, addr_out in that cycle is (segment << 4) + offset.
- R3: The memory address wraps modulo 2^20. For example, segment 0xFFFF with offset 0xFFFF gives 0x0FFEF, and segment 0xF800 with offset 0x8000 gives 0x00000.
- R4: The default segment follows the kind code. Kind 0 (fetch) uses segment 0 (code). Kind 1 (stack) uses segment 1 (stack). Kind 2 (data) and kind 3 (string source) use segment 2 (primary data). Kind 4 (string destination) uses segment 3 (extra). Segments 4 and 5 are the two further data segments.
- R5: With ovr_en high and ovr_sel in 0..5, kinds 2 and 3 use the segment named by ovr_sel.
- R6: The override has no effect on kinds 0, 1 and 4.
- R7: An override whose ovr_sel is 6 or 7 is ignored, and the default segment is used.
- R8: Kind 5 (I/O) puts {4'b0, offset} on addr_out and sets addr_is_io. Every memory result clears addr_is_io.
- R9: A segment write with seg_wr_sel in 0..5 takes effect from the next cycle. A request in the same cycle as the write still uses the old value.
- R10: A segment write with seg_wr_sel 6 or 7 changes no register.
- R11: Kind codes 6 and 7 are not legal. They produce no result: addr_valid is low in the next cycle.
- R12: Two or more segment registers may hold the same value or overlapping windows, and each one still forms addresses on its own.
- R13: In a cycle after no legal request, addr_valid is low and addr_out and addr_is_io keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 3 | Segment register to write (0..5) |
| seg_wr_data | input | 16 | Value to load |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 3 | Access kind code (0..5) |
| req_offset | input | 16 | Offset within the segment, or the port number for I/O |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 3 | Override segment (0..5) |
| addr_valid | output | 1 | Result valid, one cycle after the request |
| addr_out | output | 20 | Physical address or zero-extended port number |
| addr_is_io | output | 1 | Result lies in the I/O space |

## Verification
On every cycle, the assertions check the following:
- The valid output follows a legal request exactly one cycle later, and stays low after an illegal or absent request.
- Outputs hold their values while idle.
- I/O results carry no bits above the port width.
- Fetch and string-destination requests never reach any segment but their fixed one.
- Each segment register changes only when it is itself written, and then to the written value.

Only the bench's scenarios can show that the arithmetic is right. This covers the address sums, the wrap at 1 MB, which segment each kind and override actually picks, the ordering between a write and a request in the same cycle, and the fact that writes to unused selects leave all six registers intact.

// File: rtl/seg_agen_pkg.sv
`timescale 1ns/1ps
package seg_agen_pkg;

    localparam int NUM_SEG = 6;
    localparam int SEL_W   = 3;
    localparam int KIND_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEG_CODE  = 3'd0,
        SEG_STACK = 3'd1,
        SEG_DATA  = 3'd2,
        SEG_EXTRA = 3'd3,
        SEG_AUX_F = 3'd4,
        SEG_AUX_G = 3'd5
    } seg_id_e;

    typedef enum logic [KIND_W-1:0] {
        ACC_FETCH   = 3'd0,
        ACC_STACK   = 3'd1,
        ACC_DATA    = 3'd2,
        ACC_STR_SRC = 3'd3,
        ACC_STR_DST = 3'd4,
        ACC_IO      = 3'd5
    } acc_kind_e;

endpackage

// File: rtl/seg_regfile.sv
`timescale 1ns/1ps
module seg_regfile #(
    parameter int SEG_W   = 16,
    parameter int NUM_SEG = 6,
    parameter int SEL_W   = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en_i,
    input  logic [SEL_W-1:0]                wr_sel_i,
    input  logic [SEG_W-1:0]                wr_data_i,
    output logic [NUM_SEG-1:0][SEG_W-1:0]   seg_o
);

    typedef struct packed {
        logic [NUM_SEG-1:0][SEG_W-1:0] seg;
    } rf_state_t;

    rf_state_t st_d, st_q;

    // Next-state logic: only the selected register takes the write.
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (wr_en_i && (wr_sel_i == SEL_W'(i))) begin
                st_d.seg[i] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seg_o = st_q.seg;

    // One pair of checks per register.
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg_chk
        AST_SEG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en_i && wr_sel_i == SEL_W'(g)) |=> $stable(seg_o[g])); // R10
        AST_SEG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_sel_i == SEL_W'(g)) |=> (seg_o[g] == $past(wr_data_i))); // R9
    end

endmodule

// File: rtl/seg_select.sv
`timescale 1ns/1ps
module seg_select
    import seg_agen_pkg::*;
(
    input  logic [KIND_W-1:0] kind_i,
    input  logic              ovr_en_i,
    input  logic [SEL_W-1:0]  ovr_sel_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic              kind_ok_o,
    output logic              is_io_o
);

    logic ovr_ok;
    assign ovr_ok = ovr_en_i && (ovr_sel_i < SEL_W'(NUM_SEG));

    always_comb begin
        sel_o     = SEG_DATA;
        kind_ok_o = 1'b1;
        is_io_o   = 1'b0;
        case (kind_i)
            ACC_FETCH:   sel_o = SEG_CODE;
            ACC_STACK:   sel_o = SEG_STACK;
            ACC_DATA,
            ACC_STR_SRC: sel_o = ovr_ok ? ovr_sel_i : SEG_DATA;
            ACC_STR_DST: sel_o = SEG_EXTRA;
            ACC_IO:      is_io_o = 1'b1;
            default:     kind_ok_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/addr_former.sv
`timescale 1ns/1ps
module addr_former #(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             is_io_i,
    output logic [PA_W-1:0]  pa_o
);

    logic [PA_W-1:0] base;
    logic [PA_W-1:0] ofs_ext;
    logic [PA_W-1:0] mem_pa;

    // Base sits on a 2^SHIFT boundary.
    assign base = {seg_i, {SHIFT{1'b0}}};

    if (PA_W > OFS_W) begin : g_ext
        assign ofs_ext = {{(PA_W-OFS_W){1'b0}}, ofs_i};
    end else begin : g_trunc
        assign ofs_ext = ofs_i[PA_W-1:0];
    end

    // Sum truncated to PA_W: wraps at the top of the space.
    assign mem_pa = base + ofs_ext;
    assign pa_o   = is_io_i ? ofs_ext : mem_pa;

endmodule

// File: rtl/seg_addr_gen.sv
`timescale 1ns/1ps
module seg_addr_gen
    import seg_agen_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   seg_wr_en,
    input  logic [SEL_W-1:0]       seg_wr_sel,
    input  logic [SEG_W-1:0]       seg_wr_data,
    input  logic                   req_valid,
    input  logic [KIND_W-1:0]      req_kind,
    input  logic [OFS_W-1:0]       req_offset,
    input  logic                   ovr_en,
    input  logic [SEL_W-1:0]       ovr_sel,
    output logic                   addr_valid,
    output logic [SEG_W+SHIFT-1:0] addr_out,
    output logic                   addr_is_io
);

    localparam int PA_W = SEG_W + SHIFT;

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] addr;
        logic            io;
    } out_state_t;

    logic [NUM_SEG-1:0][SEG_W-1:0] seg_all;
    logic [SEL_W-1:0]              sel_w;
    logic                          kind_ok_w;
    logic                          is_io_w;
    logic [SEG_W-1:0]              seg_val;
    logic [PA_W-1:0]               pa_w;
    out_state_t                    st_d, st_q;

    seg_regfile #(
        .SEG_W   (SEG_W),
        .NUM_SEG (NUM_SEG),
        .SEL_W   (SEL_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (seg_wr_en),
        .wr_sel_i  (seg_wr_sel),
        .wr_data_i (seg_wr_data),
        .seg_o     (seg_all)
    );

    seg_select i_sel (
        .kind_i    (req_kind),
        .ovr_en_i  (ovr_en),
        .ovr_sel_i (ovr_sel),
        .sel_o     (sel_w),
        .kind_ok_o (kind_ok_w),
        .is_io_o   (is_io_w)
    );

    // Pick the segment value for the chosen select.
    always_comb begin
        seg_val = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (sel_w == SEL_W'(i)) begin
                seg_val = seg_all[i];
            end
        end
    end

    addr_former #(
        .SEG_W (SEG_W),
        .OFS_W (OFS_W),
        .SHIFT (SHIFT),
        .PA_W  (PA_W)
    ) i_form (
        .seg_i   (seg_val),
        .ofs_i   (req_offset),
        .is_io_i (is_io_w),
        .pa_o    (pa_w)
    );

    // Output register: set on a legal request, held otherwise.
    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid && kind_ok_w;
        if (req_valid && kind_ok_w) begin
            st_d.addr = pa_w;
            st_d.io   = is_io_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_valid = st_q.valid;
    assign addr_out   = st_q.addr;
    assign addr_is_io = st_q.io;

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind <= KIND_W'(ACC_IO)) |=> addr_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_kind <= KIND_W'(ACC_IO)) |=> !addr_valid); // R11
    AST_IO_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_is_io) |-> ((addr_out >> OFS_W) == '0)); // R8
    AST_IO_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_W'(ACC_IO)) |=> addr_is_io); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> ($stable(addr_out) && $stable(addr_is_io))); // R13
    AST_FETCH_CODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind == KIND_W'(ACC_FETCH)) |-> (sel_w == SEL_W'(SEG_CODE))); // R6
    AST_DST_EXTRA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind == KIND_W'(ACC_STR_DST)) |-> (sel_w == SEL_W'(SEG_EXTRA))); // R6
    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        kind_ok_w |-> (sel_w < SEL_W'(NUM_SEG))); // R7

endmodule

// File: tb/test_seg_addr_gen.sv
`timescale 1ns/1ps
module test_seg_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [2:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [15:0] req_offset = '0;
    logic        ovr_en = 1'b0;
    logic [2:0]  ovr_sel = '0;
    logic        addr_valid;
    logic [19:0] addr_out;
    logic        addr_is_io;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [15:0] model_seg [6];
    logic [21:0] exp_q [$];   // {valid, io, addr}
    string       tag_q [$];

    always #2.5 clk = ~clk;   // 200 MHz

    seg_addr_gen i_seg_addr_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .seg_wr_en   (seg_wr_en),
        .seg_wr_sel  (seg_wr_sel),
        .seg_wr_data (seg_wr_data),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_offset  (req_offset),
        .ovr_en      (ovr_en),
        .ovr_sel     (ovr_sel),
        .addr_valid  (addr_valid),
        .addr_out    (addr_out),
        .addr_is_io  (addr_is_io)
    );

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    // Driver: one cycle of stimulus, pushes the expected result.
    task automatic drive(input logic we, input logic [2:0] ws, input logic [15:0] wd,
                         input logic rv, input logic [2:0] k, input logic [15:0] ofs,
                         input logic oe, input logic [2:0] os, input string tag);
        logic [21:0] e;
        int          s;
        @(negedge clk);
        seg_wr_en = we; seg_wr_sel = ws; seg_wr_data = wd;
        req_valid = rv; req_kind = k; req_offset = ofs;
        ovr_en = oe; ovr_sel = os;
        e = '0;
        if (rv && k <= 3'd5) begin
            if (k == 3'd5) begin
                e = {1'b1, 1'b1, 4'h0, ofs};
            end else begin
                case (k)
                    3'd0: s = 0;
                    3'd1: s = 1;
                    3'd4: s = 3;
                    default: s = (oe && os <= 3'd5) ? int'(os) : 2;
                endcase
                e = {1'b1, 1'b0, phys(model_seg[s], ofs)};
            end
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (we && ws <= 3'd5) model_seg[ws] = wd;
    endtask

    task automatic idle(input string tag);
        drive(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic wseg(input logic [2:0] ws, input logic [15:0] wd, input string tag);
        drive(1, ws, wd, 0, 0, 0, 0, 0, tag);
    endtask

    // Monitor: compare one result per cycle, away from the clock edge.
    initial begin
        logic [19:0] last_addr = '0;
        logic        last_io = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [21:0] e;
                string       t;
                logic        ev;
                logic        eio;
                logic [19:0] ea;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                ev = e[21];
                if (ev) begin
                    eio = e[20];
                    ea = e[19:0];
                end else begin
                    eio = last_io;
                    ea = last_addr;
                end
                checks++;
                if (addr_valid !== ev || addr_out !== ea || addr_is_io !== eio) begin
                    failures++;
                    $display("FAIL %s: got valid=%0b addr=%05h io=%0b expected valid=%0b addr=%05h io=%0b",
                             t, addr_valid, addr_out, addr_is_io, ev, ea, eio);
                end
                last_addr = ea;
                last_io = eio;
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) model_seg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        #1;
        checks++;
        if (addr_valid !== 1'b0 || addr_out !== 20'h0 || addr_is_io !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset outputs: got %0b %05h %0b expected 0 00000 0",
                     addr_valid, addr_out, addr_is_io);
        end
        // R1: every segment register starts at zero
        for (int i = 0; i < 6; i++) drive(0, 0, 0, 1, 3'd2, 16'h0010, 1, 3'(i), "R1 seg zero");

        // R9: write and request in the same cycle use the old value
        drive(1, 3'd0, 16'h1234, 1, 3'd0, 16'h0005, 0, 0, "R9 same-cycle old");
        drive(0, 0, 0, 1, 3'd0, 16'h0005, 0, 0, "R9 next-cycle new");

        wseg(3'd1, 16'h2000, "R9 load stack");
        wseg(3'd2, 16'h3000, "R9 load data");
        wseg(3'd3, 16'h4000, "R9 load extra");
        wseg(3'd4, 16'h5000, "R12 load F");
        wseg(3'd5, 16'h5000, "R12 load G same");

        // R4: default segments
        drive(0, 0, 0, 1, 3'd0, 16'hABCD, 0, 0, "R4 fetch");
        drive(0, 0, 0, 1, 3'd1, 16'hFFFE, 0, 0, "R4 stack");
        drive(0, 0, 0, 1, 3'd2, 16'h0100, 0, 0, "R4 data");
        drive(0, 0, 0, 1, 3'd3, 16'h0200, 0, 0, "R4 str src");
        drive(0, 0, 0, 1, 3'd4, 16'h0300, 0, 0, "R4 str dst");
        // R2: back-to-back with varied offsets
        drive(0, 0, 0, 1, 3'd2, 16'hFFFF, 0, 0, "R2 data max ofs");
        drive(0, 0, 0, 1, 3'd2, 16'h0000, 0, 0, "R2 data zero ofs");

        // R5: override on data and string source
        drive(0, 0, 0, 1, 3'd2, 16'h0042, 1, 3'd4, "R5 data to F");
        drive(0, 0, 0, 1, 3'd3, 16'h0042, 1, 3'd1, "R5 src to stack");
        drive(0, 0, 0, 1, 3'd2, 16'h0042, 1, 3'd0, "R5 data to code");
        // R12: overlapping windows from F and G
        drive(0, 0, 0, 1, 3'd2, 16'h7777, 1, 3'd5, "R12 G same as F");
        // R6: override ignored
        drive(0, 0, 0, 1, 3'd0, 16'h0010, 1, 3'd3, "R6 fetch ovr");
        drive(0, 0, 0, 1, 3'd1, 16'h0010, 1, 3'd4, "R6 stack ovr");
        drive(0, 0, 0, 1, 3'd4, 16'h0010, 1, 3'd2, "R6 dst ovr");
        // R7: illegal override select
        drive(0, 0, 0, 1, 3'd2, 16'h0020, 1, 3'd6, "R7 ovr sel 6");
        drive(0, 0, 0, 1, 3'd3, 16'h0020, 1, 3'd7, "R7 ovr sel 7");

        // R8: I/O bypass
        drive(0, 0, 0, 1, 3'd5, 16'hBEEF, 0, 0, "R8 io");
        drive(0, 0, 0, 1, 3'd5, 16'h0001, 1, 3'd4, "R8 io with ovr");
        drive(0, 0, 0, 1, 3'd2, 16'h0001, 0, 0, "R8 mem clears io");

        // R13: idle holds
        idle("R13 idle 1");
        idle("R13 idle 2");

        // R3: wrap at 1 MB
        wseg(3'd2, 16'hFFFF, "R3 load");
        drive(0, 0, 0, 1, 3'd2, 16'hFFFF, 0, 0, "R3 wrap FFFF");
        wseg(3'd2, 16'hF800, "R3 load");
        drive(0, 0, 0, 1, 3'd2, 16'h8000, 0, 0, "R3 wrap to zero");

        // R10: illegal write selects change nothing
        wseg(3'd6, 16'hAAAA, "R10 write sel 6");
        wseg(3'd7, 16'h5555, "R10 write sel 7");
        for (int i = 0; i < 6; i++) drive(0, 0, 0, 1, 3'd2, 16'h0003, 1, 3'(i), "R10 readback");

        // R11: illegal kinds
        drive(0, 0, 0, 1, 3'd6, 16'h1111, 0, 0, "R11 kind 6");
        drive(0, 0, 0, 1, 3'd7, 16'h2222, 0, 0, "R11 kind 7");
        idle("R13 idle 3");

        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule